// File: doc/BRIEF.md
# Thermal Threshold Interrupt Unit

This unit watches the temperature codes of one sensor channel. Each time a sample strobe arrives it stores the 12-bit code, compares it with the previous code against three programmable threshold codes, and records upward and downward crossings as sticky status flags. Software programs the thresholds, chooses which crossing events may be recorded (enable) and which recorded events reach the single interrupt line (mask, where a 1 lets the event through). It then clears handled events by writing the status register.

A typical use forms a temperature window. Only the downward event of threshold 1 and the upward event of threshold 2 are enabled, so the interrupt fires when the temperature leaves the window on either side. All registers sit on a word-addressed read/write port. Reads return data one cycle after the address is presented.

Top module: `thermal_trip_irq`

## Requirements
- R1: After reset every register reads zero and the interrupt output is low.
- R2: Word addresses are status 1, mask 2, control 3, enable 4, thresholds 1..3 at 5..7, and the current code at 10. Threshold and code registers hold 12 bits, and bits above 11 read zero. Unmapped words read zero. Read data appears in the cycle after the address.
- R3: A sample strobe loads the sample code into the current-code register, readable at word 10.
- R4: Status bits 0..2 record an upward crossing of thresholds 1..3. The previous code is below the threshold, and the new code is at or above it.
- R5: Status bits 3..5 record a downward crossing of thresholds 1..3. The previous code is at or above the threshold, and the new code is below it.
- R6: The first sample after reset only primes the previous code and records no event.
- R7: A status bit is set only when the enable bit at the same position is 1.
- R8: Status bits are sticky. A write to status keeps each bit whose data bit is 1 and clears the others, so writing zero clears all.
- R9: An event arriving in the same cycle as a status write is recorded after the write has been applied, so the event wins.
- R10: The interrupt output goes high one cycle after any status bit with mask bit 1 is set. A zero mask silences it without changing status.
- R11: The control register is a 6-bit field that reads back what was written and has no other effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| smp_valid | input | 1 | Sample strobe |
| smp_code | input | 12 | Temperature code of the sample |
| reg_addr | input | 4 | Word address |
| reg_we | input | 1 | Write strobe |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Registered read data |
| irq | output | 1 | Registered interrupt output |

## Verification
The assertions assume that reset is held for at least one clock edge before the first sample. They also assume that reg_addr is a defined value in every cycle, since read data and its upper-bit check are derived from the previous address. The stimulus meets both: it holds reset for several cycles and keeps reg_addr pointing at a real word at all times. It also drives strobes and writes only between clock edges.

// File: rtl/thermal_irq_pkg.sv
package thermal_irq_pkg;
  localparam int ADDR_W = 4;
  localparam logic [ADDR_W-1:0] W_STAT = 4'd1;
  localparam logic [ADDR_W-1:0] W_MASK = 4'd2;
  localparam logic [ADDR_W-1:0] W_CTRL = 4'd3;
  localparam logic [ADDR_W-1:0] W_EN   = 4'd4;
  localparam logic [ADDR_W-1:0] W_THR0 = 4'd5;
  localparam logic [ADDR_W-1:0] W_CODE = 4'd10;
  localparam int CTRL_W = 6;
endpackage

// File: rtl/trip_compare.sv
module trip_compare #(
  parameter int CODE_W  = 12,
  parameter int NUM_THR = 3
) (
  input  logic [CODE_W-1:0]         prev_code,
  input  logic [CODE_W-1:0]         new_code,
  input  logic [NUM_THR*CODE_W-1:0] thr_flat,
  input  logic                      fire,
  output logic [2*NUM_THR-1:0]      evt
);
  for (genvar i = 0; i < NUM_THR; i++) begin : g_thr
    logic [CODE_W-1:0] t;
    assign t = thr_flat[i*CODE_W +: CODE_W];
    // upward crossings fill the low half, downward the high half
    assign evt[i]         = fire && (prev_code <  t) && (new_code >= t);
    assign evt[NUM_THR+i] = fire && (prev_code >= t) && (new_code <  t);
  end
endmodule

// File: rtl/event_latch.sv
module event_latch #(
  parameter int W = 6
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] evt_i,
  input  logic [W-1:0] en_i,
  input  logic         wr_i,
  input  logic [W-1:0] wdata_i,
  output logic [W-1:0] stat_o
);
  logic [W-1:0] stat_q;
  logic [W-1:0] kept;

  assign kept = wr_i ? (stat_q & wdata_i) : stat_q;

  always_ff @(posedge clk) begin
    if (rst) stat_q <= '0;
    else     stat_q <= kept | (evt_i & en_i);
  end

  assign stat_o = stat_q;

  assert_set_needs_enable_R7: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((stat_q & ~$past(stat_q) & ~$past(en_i)) == '0));

  assert_sticky_without_write_R8: assert property (@(posedge clk) disable iff (rst)
    !wr_i |=> ((~stat_q & $past(stat_q)) == '0));
endmodule

// File: rtl/thermal_trip_irq.sv
module thermal_trip_irq
  import thermal_irq_pkg::*;
#(
  parameter int CODE_W  = 12,
  parameter int NUM_THR = 3,
  parameter int DATA_W  = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              smp_valid,
  input  logic [CODE_W-1:0] smp_code,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic              reg_we,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output logic              irq
);
  localparam int EVT_W = 2 * NUM_THR;

  logic [CODE_W-1:0]         thr_q [NUM_THR];
  logic [NUM_THR*CODE_W-1:0] thr_flat;
  logic [CODE_W-1:0]         cur_q;
  logic                      primed_q;
  logic [EVT_W-1:0]          mask_q, en_q, stat, evt;
  logic [CTRL_W-1:0]         ctrl_q;
  logic [DATA_W-1:0]         rdata_q, rd_mux;
  logic                      irq_q;
  logic                      stat_wr;

  assign stat_wr = reg_we && (reg_addr == W_STAT);

  for (genvar i = 0; i < NUM_THR; i++) begin : g_thr
    always_ff @(posedge clk) begin
      if (rst) thr_q[i] <= '0;
      else if (reg_we && reg_addr == W_THR0 + ADDR_W'(i))
        thr_q[i] <= reg_wdata[CODE_W-1:0];
    end
    assign thr_flat[i*CODE_W +: CODE_W] = thr_q[i];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mask_q <= '0;
      en_q   <= '0;
      ctrl_q <= '0;
    end else if (reg_we) begin
      if (reg_addr == W_MASK) mask_q <= reg_wdata[EVT_W-1:0];
      if (reg_addr == W_EN)   en_q   <= reg_wdata[EVT_W-1:0];
      if (reg_addr == W_CTRL) ctrl_q <= reg_wdata[CTRL_W-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cur_q    <= '0;
      primed_q <= 1'b0;
    end else if (smp_valid) begin
      cur_q    <= smp_code;
      primed_q <= 1'b1;
    end
  end

  trip_compare #(.CODE_W(CODE_W), .NUM_THR(NUM_THR)) u_cmp (
    .prev_code (cur_q),
    .new_code  (smp_code),
    .thr_flat  (thr_flat),
    .fire      (smp_valid && primed_q),
    .evt       (evt)
  );

  event_latch #(.W(EVT_W)) u_latch (
    .clk     (clk),
    .rst     (rst),
    .evt_i   (evt),
    .en_i    (en_q),
    .wr_i    (stat_wr),
    .wdata_i (reg_wdata[EVT_W-1:0]),
    .stat_o  (stat)
  );

  always_comb begin
    rd_mux = '0;
    if (reg_addr == W_STAT) rd_mux[EVT_W-1:0]  = stat;
    if (reg_addr == W_MASK) rd_mux[EVT_W-1:0]  = mask_q;
    if (reg_addr == W_CTRL) rd_mux[CTRL_W-1:0] = ctrl_q;
    if (reg_addr == W_EN)   rd_mux[EVT_W-1:0]  = en_q;
    if (reg_addr == W_CODE) rd_mux[CODE_W-1:0] = cur_q;
    for (int i = 0; i < NUM_THR; i++)
      if (reg_addr == W_THR0 + ADDR_W'(i)) rd_mux[CODE_W-1:0] = thr_q[i];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata_q <= '0;
      irq_q   <= 1'b0;
    end else begin
      rdata_q <= rd_mux;
      irq_q   <= |(stat & mask_q);
    end
  end

  assign reg_rdata = rdata_q;
  assign irq       = irq_q;

  assert_irq_has_cause_R10: assert property (@(posedge clk) disable iff (rst)
    irq |-> ($past(stat) != '0));

  assert_code_holds_R3: assert property (@(posedge clk) disable iff (rst)
    !smp_valid |=> $stable(cur_q));

  assert_thr_upper_zero_R2: assert property (@(posedge clk) disable iff (rst)
    ($past(reg_addr) == W_THR0) |-> (reg_rdata[DATA_W-1:CODE_W] == '0));

  assert_first_sample_quiet_R6: assert property (@(posedge clk) disable iff (rst)
    (smp_valid && !primed_q && !stat_wr) |=> $stable(stat));
endmodule

// File: tb/thermal_trip_irq_test.sv
module thermal_trip_irq_test;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        smp_valid = 1'b0;
  logic [11:0] smp_code = '0;
  logic [3:0]  reg_addr = 4'd1;
  logic        reg_we = 1'b0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        irq;

  int tests = 0;
  int fails = 0;
  bit done  = 1'b0;

  logic [11:0] thr [3];
  logic [11:0] prev;
  logic [5:0]  exp_stat, en, mask;
  logic [31:0] d;

  always #(CLK_PERIOD/2) clk = ~clk;

  thermal_trip_irq uut (
    .clk(clk), .rst(rst), .smp_valid(smp_valid), .smp_code(smp_code),
    .reg_addr(reg_addr), .reg_we(reg_we), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .irq(irq)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] v);
    @(negedge clk);
    reg_addr = a; reg_we = 1'b1; reg_wdata = v;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] v);
    @(negedge clk);
    reg_addr = a;
    @(posedge clk);
    #1 v = reg_rdata;
  endtask

  task automatic sample(input logic [11:0] c);
    @(negedge clk);
    smp_valid = 1'b1; smp_code = c;
    @(negedge clk);
    smp_valid = 1'b0;
  endtask

  function automatic logic [5:0] crossings(input logic [11:0] p, input logic [11:0] n);
    logic [5:0] e = '0;
    for (int i = 0; i < 3; i++) begin
      if (p <  thr[i] && n >= thr[i]) e[i]   = 1'b1;
      if (p >= thr[i] && n <  thr[i]) e[3+i] = 1'b1;
    end
    return e;
  endfunction

  task automatic step(input logic [11:0] c);
    sample(c);
    exp_stat = exp_stat | (crossings(prev, c) & en);
    prev = c;
    rd(4'd1, d);
    chk("R4/R5/R7 status", d, {26'd0, exp_stat});
    chk("R10 irq", {31'd0, irq}, {31'd0, |(exp_stat & mask)});
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 irq after reset", {31'd0, irq}, 32'd0);
    for (int a = 0; a < 16; a++) begin
      rd(4'(a), d);
      chk("R1 register after reset", d, 32'd0);
    end

    thr[0] = 12'd100; thr[1] = 12'd200; thr[2] = 12'd300;
    wr(4'd5, 32'hFFFF_F064);
    rd(4'd5, d); chk("R2 threshold 1 upper bits", d, 32'h064);
    wr(4'd6, 32'd200); wr(4'd7, 32'd300);
    rd(4'd6, d); chk("R2 threshold 2", d, 32'd200);
    rd(4'd7, d); chk("R2 threshold 3", d, 32'd300);
    rd(4'd9, d); chk("R2 unmapped", d, 32'd0);

    wr(4'd3, 32'hFFFF_FFEA);
    rd(4'd3, d); chk("R11 control readback", d, 32'h2A);

    en = 6'h3F; mask = 6'h3F;
    wr(4'd4, 32'h3F); wr(4'd2, 32'h3F);
    rd(4'd10, d); chk("R1 code before sample", d, 32'd0);
    sample(12'd500);
    rd(4'd1, d); chk("R6 first sample no event", d, 32'd0);
    rd(4'd10, d); chk("R3 code captured", d, 32'd500);
    chk("R11 control has no effect on irq", {31'd0, irq}, 32'd0);
    prev = 12'd500; exp_stat = '0;

    step(12'd0);
    chk("R5 all downward", {26'd0, exp_stat}, 32'h38);
    wr(4'd1, 32'h08); exp_stat = 6'h08;
    rd(4'd1, d); chk("R8 partial clear", d, 32'h08);
    wr(4'd1, 32'd0); exp_stat = '0;
    rd(4'd1, d); chk("R8 zero clears all", d, 32'd0);

    for (int i = 0; i < 64; i++) begin
      logic [11:0] c;
      c = 12'((i * 37 + (i % 5) * 53) % 400);
      step(c);
      rd(4'd10, d); chk("R3 code tracks sample", d, {20'd0, c});
      if (i % 8 == 7) begin
        wr(4'd1, 32'd0); exp_stat = '0;
      end
    end

    en = 6'h0A; mask = 6'h00;
    wr(4'd4, 32'h0A); wr(4'd2, 32'h00); wr(4'd1, 32'd0); exp_stat = '0;
    for (int i = 0; i < 48; i++) step(12'((i * 71) % 380));
    rd(4'd1, d);
    chk("R10 mask zero keeps status", d, {26'd0, exp_stat});
    chk("R10 mask zero silences irq", {31'd0, irq}, 32'd0);
    wr(4'd2, 32'h3F); mask = 6'h3F;
    @(negedge clk);
    chk("R10 irq after unmask", {31'd0, irq}, {31'd0, |exp_stat});

    en = 6'h3F;
    wr(4'd4, 32'h3F);
    step(12'd50); step(12'd150);
    wr(4'd1, 32'd0); exp_stat = '0;
    @(negedge clk);
    smp_valid = 1'b1; smp_code = 12'd50;
    reg_addr = 4'd1; reg_we = 1'b1; reg_wdata = 32'd0;
    @(negedge clk);
    smp_valid = 1'b0; reg_we = 1'b0;
    rd(4'd1, d); chk("R9 event beats clear", d, 32'h08);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog: actual hung expected done");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule